// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block ties a primary and a secondary eight-line interrupt priority core into one fifteen-source interrupt system. The priority cores themselves stay outside: each one reports its current winning line, and this unit tells each core what to do when the processor acknowledges an interrupt. Whenever the secondary core shows a new winner, the unit raises the cascade request for one cycle and then drops it. The primary core's edge detector then sees a request on its cascade line (line 2 by default).

An acknowledge strobe starts a short sequence in the acknowledge state machine, which has two states. In `A_IDLE` an accepted strobe takes the transition *accept* to `A_RESP`, and `A_RESP` always takes *retire* back to `A_IDLE`. On *accept* the unit sends the primary winner an acknowledge command. If that winner is the cascade line, the secondary winner also gets one. The command says whether to set the in-service bit, whether to clear the request bit and whether to move the rotation base. The unit also forms the 8-bit vector from the matching 5-bit base and the line number. Empty cases give a spurious vector with line field 7. The cascade state machine has three states: `C_IDLE`, `C_RAISE` (request high) and `C_DROP` (request low). Its transitions are *trigger* (`C_IDLE`→`C_RAISE`), *lower* (`C_RAISE`→`C_DROP`), *repeat* (`C_DROP`→`C_RAISE`, taken when a trigger arrived meanwhile) and *settle* (`C_DROP`→`C_IDLE`).

The unit also holds one trigger-mode register per core, in which a bit set to 1 marks that line as level sensitive. Each register has fixed bits that cannot be written, and the unit drives the stored values to the cores.

Top module: `casc_ack_unit`

## Requirements
- R1: A write with `tm_sel`=0 stores `tm_wdata & 8'hF8` in the primary trigger-mode register. With `tm_sel`=1 it stores `tm_wdata & 8'hDE` in the secondary one. The other register does not change, and without `tm_we` neither register changes.
- R2: `tm_rdata` returns the register chosen by `tm_sel` (0 primary, 1 secondary). Both registers reset to 0, and `m_trig_mode`/`s_trig_mode` always show the stored values.
- R3: When the secondary core's winner becomes valid, or changes line, or the cycle after a secondary acknowledge command while a winner is still valid, `casc_req` is high for exactly one cycle and low for at least the next one.
- R4: If the primary winner is valid and is not the cascade line, the vector is `{m_vec_base, line}`. Only the primary core gets a command, and it carries that line.
- R5: If the primary winner is the cascade line and the secondary winner is valid, both cores get a command and the vector is `{s_vec_base, secondary line}`.
- R6: If the primary winner is the cascade line and there is no secondary winner, the vector is `{s_vec_base, 3'd7}`. The primary core is acknowledged and the secondary core is not.
- R7: With no primary winner the vector is `{m_vec_base, 3'd7}` and neither core gets a command, so no in-service bit is set.
- R8: A command sets `isr_set` unless that core's auto-EOI input is 1. If auto-EOI and rotate-on-auto-EOI are both 1, the command raises `rot_upd` with `rot_base` = (line + 1) mod 8.
- R9: A command raises `irr_clr` only when that line's trigger-mode bit is 0 (edge). A level line stays pending.
- R10: `ack_done` is high for one cycle, the cycle after an accepted strobe, and the vector and commands are valid in that same cycle. A strobe seen while `ack_done` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ack_req | input | 1 | Acknowledge strobe |
| m_win_vld | input | 1 | Primary core has a winner |
| m_win_line | input | 3 | Primary winning line |
| s_win_vld | input | 1 | Secondary core has a winner |
| s_win_line | input | 3 | Secondary winning line |
| m_vec_base | input | 5 | Primary vector base (upper vector bits) |
| s_vec_base | input | 5 | Secondary vector base |
| m_auto_eoi | input | 1 | Primary auto end-of-interrupt |
| m_rot_aeoi | input | 1 | Primary rotate on auto end-of-interrupt |
| s_auto_eoi | input | 1 | Secondary auto end-of-interrupt |
| s_rot_aeoi | input | 1 | Secondary rotate on auto end-of-interrupt |
| tm_we | input | 1 | Trigger-mode write enable |
| tm_sel | input | 1 | Trigger-mode register select |
| tm_wdata | input | 8 | Trigger-mode write data |
| tm_rdata | output | 8 | Selected trigger-mode value |
| m_trig_mode | output | 8 | Primary trigger modes (1 = level) |
| s_trig_mode | output | 8 | Secondary trigger modes |
| casc_req | output | 1 | Cascade request to the primary core's cascade line |
| ack_done | output | 1 | Acknowledge result valid |
| ack_vec | output | 8 | Interrupt vector |
| m_ack_stb | output | 1 | Primary acknowledge command |
| m_ack_line | output | 3 | Primary line acknowledged |
| m_isr_set | output | 1 | Primary: set in-service bit |
| m_irr_clr | output | 1 | Primary: clear request bit |
| m_rot_upd | output | 1 | Primary: load rotation base |
| m_rot_base | output | 3 | Primary new rotation base |
| s_ack_stb | output | 1 | Secondary acknowledge command |
| s_ack_line | output | 3 | Secondary line acknowledged |
| s_isr_set | output | 1 | Secondary: set in-service bit |
| s_irr_clr | output | 1 | Secondary: clear request bit |
| s_rot_upd | output | 1 | Secondary: load rotation base |
| s_rot_base | output | 3 | Secondary new rotation base |

## Verification
The assertions assume that the winner line inputs mean something only while their valid flags are high. They also assume the auto-EOI and base inputs do not change in the cycle an acknowledge is accepted. Nothing else is assumed about the strobe, so `ack_req` may be held high, as the busy-strobe test does. The bench changes every input on the falling edge and leaves an idle cycle between table entries. It gives the cascade state machine time to settle before the test that checks the repeated cascade after a secondary acknowledge.

// File: rtl/casc_ack_pkg.sv
package casc_ack_pkg;

    typedef enum logic {
        A_IDLE = 1'b0,
        A_RESP = 1'b1
    } ack_state_e;

    typedef enum logic [1:0] {
        C_IDLE  = 2'd0,
        C_RAISE = 2'd1,
        C_DROP  = 2'd2
    } casc_state_e;

endpackage

// File: rtl/casc_trig_regs.sv
module casc_trig_regs #(
    parameter int          DW     = 8,
    parameter logic [7:0]  M_MASK = 8'hF8,
    parameter logic [7:0]  S_MASK = 8'hDE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] m_tm,
    output logic [DW-1:0] s_tm
);

    localparam logic [DW-1:0] MM = DW'(M_MASK);
    localparam logic [DW-1:0] SM = DW'(S_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tm <= '0;
            s_tm <= '0;
        end else if (we) begin
            if (sel) s_tm <= wdata & SM;
            else     m_tm <= wdata & MM;
        end
    end

    always_comb rdata = sel ? s_tm : m_tm;

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(m_tm) && $stable(s_tm)));

    p_other_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sel) |=> $stable(s_tm));

endmodule

// File: rtl/casc_req_fsm.sv
module casc_req_fsm #(
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_vld,
    input  logic [LW-1:0] s_line,
    input  logic          s_acked,
    output logic          casc_req
);
    import casc_ack_pkg::*;

    casc_state_e   state, state_n;
    logic          vld_q;
    logic [LW-1:0] line_q;
    logic          pend, pend_n;
    logic          trig;

    always_comb trig = s_vld && (!vld_q || (s_line != line_q) || s_acked);

    always_comb begin
        state_n = state;
        pend_n  = pend;
        unique case (state)
            C_IDLE:  if (trig) state_n = C_RAISE;
            C_RAISE: begin
                state_n = C_DROP;
                if (trig) pend_n = 1'b1;
            end
            C_DROP: begin
                state_n = (pend || trig) ? C_RAISE : C_IDLE;
                pend_n  = 1'b0;
            end
            default: state_n = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= C_IDLE;
            pend   <= 1'b0;
            vld_q  <= 1'b0;
            line_q <= '0;
        end else begin
            state  <= state_n;
            pend   <= pend_n;
            vld_q  <= s_vld;
            line_q <= s_line;
        end
    end

    always_comb casc_req = (state == C_RAISE);

    p_casc_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        casc_req |=> !casc_req);

    p_casc_on_new_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_vld) && !casc_req) |=> casc_req);

endmodule

// File: rtl/casc_ack_engine.sv
module casc_ack_engine #(
    parameter int LW        = 3,
    parameter int VW        = 8,
    parameter int CASC_LINE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_req,
    input  logic             m_vld,
    input  logic [LW-1:0]    m_line,
    input  logic             s_vld,
    input  logic [LW-1:0]    s_line,
    input  logic [VW-LW-1:0] m_base,
    input  logic [VW-LW-1:0] s_base,
    input  logic             m_aeoi,
    input  logic             m_rot,
    input  logic             s_aeoi,
    input  logic             s_rot,
    input  logic [(1<<LW)-1:0] m_tm,
    input  logic [(1<<LW)-1:0] s_tm,
    output logic             done,
    output logic [VW-1:0]    vec,
    output logic             m_stb,
    output logic [LW-1:0]    m_aline,
    output logic             m_isr,
    output logic             m_irr,
    output logic             m_rupd,
    output logic [LW-1:0]    m_rbase,
    output logic             s_stb,
    output logic [LW-1:0]    s_aline,
    output logic             s_isr,
    output logic             s_irr,
    output logic             s_rupd,
    output logic [LW-1:0]    s_rbase
);
    import casc_ack_pkg::*;

    localparam logic [LW-1:0] CL    = LW'(CASC_LINE);
    localparam logic [LW-1:0] SPUR  = '1;

    ack_state_e    state, state_n;
    logic          accept;
    logic          d_m, d_s;
    logic [VW-1:0] d_vec;

    always_comb accept = (state == A_IDLE) && ack_req;

    always_comb begin
        unique case (state)
            A_IDLE:  state_n = ack_req ? A_RESP : A_IDLE;
            A_RESP:  state_n = A_IDLE;
            default: state_n = A_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= A_IDLE;
        else        state <= state_n;
    end

    // winner selection and vector formation
    always_comb begin
        d_m   = 1'b0;
        d_s   = 1'b0;
        d_vec = {m_base, SPUR};
        if (m_vld) begin
            d_m = 1'b1;
            if (m_line == CL) begin
                if (s_vld) begin
                    d_s   = 1'b1;
                    d_vec = {s_base, s_line};
                end else begin
                    d_vec = {s_base, SPUR};
                end
            end else begin
                d_vec = {m_base, m_line};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            vec     <= '0;
            m_stb   <= 1'b0; m_aline <= '0; m_isr <= 1'b0;
            m_irr   <= 1'b0; m_rupd  <= 1'b0; m_rbase <= '0;
            s_stb   <= 1'b0; s_aline <= '0; s_isr <= 1'b0;
            s_irr   <= 1'b0; s_rupd  <= 1'b0; s_rbase <= '0;
        end else begin
            done   <= accept;
            m_stb  <= accept && d_m;
            m_isr  <= accept && d_m && !m_aeoi;
            m_irr  <= accept && d_m && !m_tm[m_line];
            m_rupd <= accept && d_m && m_aeoi && m_rot;
            s_stb  <= accept && d_s;
            s_isr  <= accept && d_s && !s_aeoi;
            s_irr  <= accept && d_s && !s_tm[s_line];
            s_rupd <= accept && d_s && s_aeoi && s_rot;
            if (accept) begin
                vec     <= d_vec;
                m_aline <= m_line;
                m_rbase <= m_line + 1'b1;
                s_aline <= s_line;
                s_rbase <= s_line + 1'b1;
            end
        end
    end

    p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == A_IDLE && ack_req) |=> done);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_cmd_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_stb |-> done);

    p_slave_via_cascade_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_stb |-> (m_stb && m_aline == CL));

    p_spurious_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !m_stb) |-> (!s_stb && !m_isr && vec[LW-1:0] == SPUR));

endmodule

// File: rtl/casc_ack_unit.sv
module casc_ack_unit #(
    parameter int          LINES     = 8,
    parameter int          VEC_W     = 8,
    parameter int          CASC_LINE = 2,
    parameter logic [7:0]  M_TM_MASK = 8'hF8,
    parameter logic [7:0]  S_TM_MASK = 8'hDE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ack_req,
    input  logic        m_win_vld,
    input  logic [2:0]  m_win_line,
    input  logic        s_win_vld,
    input  logic [2:0]  s_win_line,
    input  logic [4:0]  m_vec_base,
    input  logic [4:0]  s_vec_base,
    input  logic        m_auto_eoi,
    input  logic        m_rot_aeoi,
    input  logic        s_auto_eoi,
    input  logic        s_rot_aeoi,
    input  logic        tm_we,
    input  logic        tm_sel,
    input  logic [7:0]  tm_wdata,
    output logic [7:0]  tm_rdata,
    output logic [7:0]  m_trig_mode,
    output logic [7:0]  s_trig_mode,
    output logic        casc_req,
    output logic        ack_done,
    output logic [7:0]  ack_vec,
    output logic        m_ack_stb,
    output logic [2:0]  m_ack_line,
    output logic        m_isr_set,
    output logic        m_irr_clr,
    output logic        m_rot_upd,
    output logic [2:0]  m_rot_base,
    output logic        s_ack_stb,
    output logic [2:0]  s_ack_line,
    output logic        s_isr_set,
    output logic        s_irr_clr,
    output logic        s_rot_upd,
    output logic [2:0]  s_rot_base
);

    localparam int LW = $clog2(LINES);

    casc_trig_regs #(
        .DW(LINES), .M_MASK(M_TM_MASK), .S_MASK(S_TM_MASK)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(tm_we), .sel(tm_sel),
        .wdata(tm_wdata), .rdata(tm_rdata),
        .m_tm(m_trig_mode), .s_tm(s_trig_mode)
    );

    casc_req_fsm #(.LW(LW)) u_casc (
        .clk(clk), .rst_n(rst_n), .s_vld(s_win_vld), .s_line(s_win_line),
        .s_acked(s_ack_stb), .casc_req(casc_req)
    );

    casc_ack_engine #(.LW(LW), .VW(VEC_W), .CASC_LINE(CASC_LINE)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req),
        .m_vld(m_win_vld), .m_line(m_win_line),
        .s_vld(s_win_vld), .s_line(s_win_line),
        .m_base(m_vec_base), .s_base(s_vec_base),
        .m_aeoi(m_auto_eoi), .m_rot(m_rot_aeoi),
        .s_aeoi(s_auto_eoi), .s_rot(s_rot_aeoi),
        .m_tm(m_trig_mode), .s_tm(s_trig_mode),
        .done(ack_done), .vec(ack_vec),
        .m_stb(m_ack_stb), .m_aline(m_ack_line), .m_isr(m_isr_set),
        .m_irr(m_irr_clr), .m_rupd(m_rot_upd), .m_rbase(m_rot_base),
        .s_stb(s_ack_stb), .s_aline(s_ack_line), .s_isr(s_isr_set),
        .s_irr(s_irr_clr), .s_rupd(s_rot_upd), .s_rbase(s_rot_base)
    );

endmodule

// File: tb/casc_ack_unit_bench.sv
module casc_ack_unit_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       ack_req = 0, m_win_vld = 0, s_win_vld = 0;
    logic [2:0] m_win_line = 0, s_win_line = 0;
    logic [4:0] m_vec_base = 5'h01, s_vec_base = 5'h0E;
    logic       m_auto_eoi = 0, m_rot_aeoi = 0, s_auto_eoi = 0, s_rot_aeoi = 0;
    logic       tm_we = 0, tm_sel = 0;
    logic [7:0] tm_wdata = 0;
    logic [7:0] tm_rdata, m_trig_mode, s_trig_mode, ack_vec;
    logic       casc_req, ack_done;
    logic       m_ack_stb, m_isr_set, m_irr_clr, m_rot_upd;
    logic       s_ack_stb, s_isr_set, s_irr_clr, s_rot_upd;
    logic [2:0] m_ack_line, m_rot_base, s_ack_line, s_rot_base;

    casc_ack_unit u_casc_ack_unit (.*);

    int total = 0;
    int fails = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {m_vld, m_line[3], s_vld, s_line[3], m_aeoi, m_rot, s_aeoi, s_rot, vec[8]}
    localparam logic [19:0] TAB [9] = '{
        {1'b1, 3'd0, 1'b0, 3'd0, 4'b0000, 8'h08},
        {1'b1, 3'd5, 1'b0, 3'd0, 4'b0000, 8'h0D},
        {1'b1, 3'd2, 1'b1, 3'd3, 4'b0000, 8'h73},
        {1'b1, 3'd2, 1'b0, 3'd0, 4'b0000, 8'h77},
        {1'b0, 3'd0, 1'b0, 3'd0, 4'b0000, 8'h0F},
        {1'b1, 3'd7, 1'b0, 3'd0, 4'b1100, 8'h0F},
        {1'b1, 3'd2, 1'b1, 3'd5, 4'b0011, 8'h75},
        {1'b1, 3'd2, 1'b1, 3'd0, 4'b1000, 8'h70},
        {1'b1, 3'd1, 1'b1, 3'd4, 4'b0000, 8'h09}
    };

    localparam logic [7:0] M_TM_EXP = 8'hF8;
    localparam logic [7:0] S_TM_EXP = 8'hDE;

    task automatic tm_write(input bit sel, input logic [7:0] d);
        @(negedge clk);
        tm_we = 1; tm_sel = sel; tm_wdata = d;
        @(negedge clk);
        tm_we = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        tm_sel = 0;
        #0 check(tm_rdata == 8'h00, "R2 reset primary", tm_rdata, 0);
        tm_sel = 1;
        #1 check(tm_rdata == 8'h00, "R2 reset secondary", tm_rdata, 0);
        check(!ack_done && !casc_req && !m_ack_stb && !s_ack_stb, "R10 reset idle",
              {ack_done, casc_req, m_ack_stb, s_ack_stb}, 0);

        // trigger-mode masking
        tm_write(0, 8'hFF);
        tm_write(1, 8'h21);
        tm_sel = 1; #1
        check(tm_rdata == 8'h00, "R1 secondary mask 21", tm_rdata, 0);
        tm_write(1, 8'hFF);
        tm_sel = 0; #1
        check(tm_rdata == M_TM_EXP, "R1 primary mask", tm_rdata, M_TM_EXP);
        tm_sel = 1; #1
        check(tm_rdata == S_TM_EXP, "R2 select secondary", tm_rdata, S_TM_EXP);
        check(m_trig_mode == M_TM_EXP && s_trig_mode == S_TM_EXP, "R2 mode outputs",
              {m_trig_mode, s_trig_mode}, {M_TM_EXP, S_TM_EXP});
        @(negedge clk);
        tm_wdata = 8'h00; tm_sel = 0;
        @(negedge clk);
        check(m_trig_mode == M_TM_EXP, "R1 no write without enable", m_trig_mode, M_TM_EXP);

        // table-driven acknowledge vectors
        for (int i = 0; i < 9; i++) begin
            logic [19:0] e;
            logic mv, sv, ma, mr, sa, sr, exp_s;
            logic [2:0] ml, sl;
            e = TAB[i];
            {mv, ml, sv, sl, ma, mr, sa, sr} = e[19:8];
            @(negedge clk);
            m_win_vld = mv; m_win_line = ml; s_win_vld = sv; s_win_line = sl;
            m_auto_eoi = ma; m_rot_aeoi = mr; s_auto_eoi = sa; s_rot_aeoi = sr;
            ack_req = 1;
            @(negedge clk);
            ack_req = 0;
            exp_s = mv && (ml == 3'd2) && sv;
            check(ack_done && ack_vec == e[7:0], $sformatf("R10/R4-R7 vector %0d", i),
                  {ack_done, ack_vec}, {1'b1, e[7:0]});
            check(m_ack_stb == mv && (!mv || m_ack_line == ml), $sformatf("R4 primary cmd %0d", i),
                  {m_ack_stb, m_ack_line}, {mv, ml});
            check(m_isr_set == (mv && !ma) && m_rot_upd == (mv && ma && mr)
                  && (!m_rot_upd || m_rot_base == ml + 3'd1),
                  $sformatf("R8 primary isr/rot %0d", i),
                  {m_isr_set, m_rot_upd, m_rot_base}, {mv && !ma, mv && ma && mr, ml + 3'd1});
            check(m_irr_clr == (mv && !M_TM_EXP[ml]), $sformatf("R9 primary irr %0d", i),
                  m_irr_clr, mv && !M_TM_EXP[ml]);
            check(s_ack_stb == exp_s && (!exp_s || s_ack_line == sl), $sformatf("R5/R6 secondary cmd %0d", i),
                  {s_ack_stb, s_ack_line}, {exp_s, sl});
            check(s_isr_set == (exp_s && !sa) && s_rot_upd == (exp_s && sa && sr)
                  && s_irr_clr == (exp_s && !S_TM_EXP[sl])
                  && (!s_rot_upd || s_rot_base == sl + 3'd1),
                  $sformatf("R8/R9 secondary flags %0d", i),
                  {s_isr_set, s_rot_upd, s_irr_clr, s_rot_base},
                  {exp_s && !sa, exp_s && sa && sr, exp_s && !S_TM_EXP[sl], sl + 3'd1});
            @(negedge clk);
        end

        // strobe held while result is shown is ignored
        m_win_vld = 1; m_win_line = 3'd4; s_win_vld = 0;
        m_auto_eoi = 0; m_rot_aeoi = 0; s_auto_eoi = 0; s_rot_aeoi = 0;
        ack_req = 1;
        @(negedge clk);
        check(ack_done && ack_vec == 8'h0C, "R10 first strobe", {ack_done, ack_vec}, 9'h10C);
        @(negedge clk);
        ack_req = 0;
        check(!ack_done && !m_ack_stb, "R10 busy strobe ignored", {ack_done, m_ack_stb}, 0);
        repeat (4) @(negedge clk);

        // cascade pulse on new secondary winner
        check(!casc_req, "R3 quiet before", casc_req, 0);
        s_win_vld = 1; s_win_line = 3'd6;
        @(negedge clk);
        check(casc_req, "R3 pulse high", casc_req, 1);
        @(negedge clk);
        check(!casc_req, "R3 pulse low", casc_req, 0);
        @(negedge clk);
        check(!casc_req, "R3 no repeat", casc_req, 0);
        repeat (2) @(negedge clk);

        // secondary acknowledge re-raises cascade while winner remains
        m_win_vld = 1; m_win_line = 3'd2;
        ack_req = 1;
        @(negedge clk);
        ack_req = 0;
        check(s_ack_stb && !casc_req, "R3 secondary acked", {s_ack_stb, casc_req}, 2'b10);
        @(negedge clk);
        check(casc_req, "R3 repeat after ack", casc_req, 1);
        @(negedge clk);
        check(!casc_req, "R3 repeat drops", casc_req, 0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule